// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block forms the full unsigned product of two N-bit operands in a single combinational pass. A square grid of carry-save cells does the accumulation: every cell ANDs one multiplicand bit with one multiplier bit and adds that partial-product bit to a sum and a carry that arrive diagonally from the row above. Each row therefore passes its result on as a pair of vectors and never waits for a carry to ripple.

Row j works on multiplier bit j and lands one place further left than row j-1. The lowest sum bit of every row is already final, so it becomes product bit j. After the last row, the leftover sum and carry vectors go to one ripple carry-propagate row of full adders, and that row produces the upper N product bits. The default width is 16, giving a 32-bit product. The block has no clock and no reset, and it holds no state.

Top module: `cs_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `product_o` equals `mcand_i * mplier_i` over the full 2N bits. This holds at the default width of 16 and also at a width of 4.
- R2: At width 4, 15 times 15 yields the 8-bit value 8'b11100001 (225).
- R3: If either operand is zero, the product is zero.
- R4: If one operand is 1, the product is the other operand zero-extended to 2N bits.
- R5: Each carry-save row preserves value. The weighted sum of its sum-out vector plus twice its carry-out vector equals sum-in plus carry-in plus the partial-product vector (multiplicand AND the row's multiplier bit).
- R6: For the carry-propagate row, its N-bit sum plus 2^N times its carry-out equals x + y + carry-in.
- R7: The carry out of the final carry-propagate row is always zero.
- R8: At width 16, all-ones times all-ones yields 32'hFFFE0001.
- R9: The block is purely combinational. A change at the inputs shows at `product_o` in the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | WIDTH | Unsigned multiplicand |
| mplier_i | input | WIDTH | Unsigned multiplier; bit j drives row j |
| product_o | output | 2*WIDTH | Unsigned product |

## Verification
The assertions sit next to the logic they guard. They check value conservation across every carry-save row and across the ripple row, that no carry leaves the top of the product, and that the product matches the arithmetic reference. They re-evaluate whenever the inputs change. Only the bench's scenarios can show the named operand cases: the 4-bit all-ones product, the zero and identity operands, the 16-bit all-ones corner, and the same-step settling of the output.

// File: rtl/cs_mult_pkg.sv
package cs_mult_pkg;

    // Two-bit result of a single carry-save or full-adder cell.
    typedef struct packed {
        logic carry;
        logic sum;
    } bit_pair_t;

    // Width needed to hold the conservation sums of a row.
    function automatic int row_check_width(input int w);
        return w + 2;
    endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell
    import cs_mult_pkg::*;
(
    input  logic mcand_bit_i,
    input  logic mplier_bit_i,
    input  logic sum_i,
    input  logic carry_i,
    output logic sum_o,
    output logic carry_o
);

    logic      pp_d;
    bit_pair_t res_d;

    always_comb begin
        pp_d  = mcand_bit_i & mplier_bit_i;
        res_d = bit_pair_t'({1'b0, sum_i} + {1'b0, pp_d} + {1'b0, carry_i});
    end

    assign sum_o   = res_d.sum;
    assign carry_o = res_d.carry;

endmodule

// File: rtl/csa_row.sv
module csa_row
    import cs_mult_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] mcand_i,
    input  logic             mbit_i,
    input  logic [WIDTH-1:0] sum_in_i,
    input  logic [WIDTH-1:0] carry_in_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] carry_o
);

    localparam int CW = row_check_width(WIDTH);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        csa_cell u_cell (
            .mcand_bit_i (mcand_i[i]),
            .mplier_bit_i(mbit_i),
            .sum_i       (sum_in_i[i]),
            .carry_i     (carry_in_i[i]),
            .sum_o       (sum_o[i]),
            .carry_o     (carry_o[i])
        );
    end

    logic [CW-1:0] out_val_d;
    logic [CW-1:0] in_val_d;

    always_comb begin
        out_val_d = CW'(sum_o) + (CW'(carry_o) << 1);
        in_val_d  = CW'(sum_in_i) + CW'(carry_in_i) + CW'(mcand_i & {WIDTH{mbit_i}});
        if (!$isunknown({mcand_i, mbit_i, sum_in_i, carry_in_i})) begin
            // R5
            row_conserve_chk: assert (out_val_d == in_val_d)
                else $error("row value not conserved: out %0h in %0h", out_val_d, in_val_d);
        end
    end

endmodule

// File: rtl/fa_cell.sv
module fa_cell
    import cs_mult_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic sum_o,
    output logic carry_o
);

    bit_pair_t res_d;

    always_comb begin
        res_d.sum   = x_i ^ y_i ^ c_i;
        res_d.carry = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
    end

    assign sum_o   = res_d.sum;
    assign carry_o = res_d.carry;

endmodule

// File: rtl/cpa_ripple.sv
module cpa_ripple #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar k = 0; k < WIDTH; k++) begin : g_fa
        fa_cell u_fa (
            .x_i    (x_i[k]),
            .y_i    (y_i[k]),
            .c_i    (chain[k]),
            .sum_o  (sum_o[k]),
            .carry_o(chain[k+1])
        );
    end

    assign cout_o = chain[WIDTH];

    always_comb begin
        if (!$isunknown({x_i, y_i, cin_i})) begin
            // R6
            ripple_sum_chk: assert ({cout_o, sum_o} == ((WIDTH+1)'(x_i) + (WIDTH+1)'(y_i) + (WIDTH+1)'(cin_i)))
                else $error("ripple row sum mismatch");
        end
    end

endmodule

// File: rtl/cs_array_mult.sv
module cs_array_mult #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]   mcand_i,
    input  logic [WIDTH-1:0]   mplier_i,
    output logic [2*WIDTH-1:0] product_o
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0] row_sum   [WIDTH];
    logic [WIDTH-1:0] row_carry [WIDTH];
    logic [WIDTH-1:0] low_bits;
    logic [WIDTH-1:0] high_bits;
    logic             final_cout;

    for (genvar j = 0; j < WIDTH; j++) begin : g_row
        logic [WIDTH-1:0] si_w;
        logic [WIDTH-1:0] ci_w;

        if (j == 0) begin : g_first
            assign si_w = '0;
            assign ci_w = '0;
        end else begin : g_next
            assign si_w = {1'b0, row_sum[j-1][WIDTH-1:1]};
            assign ci_w = row_carry[j-1];
        end

        csa_row #(.WIDTH(WIDTH)) u_row (
            .mcand_i   (mcand_i),
            .mbit_i    (mplier_i[j]),
            .sum_in_i  (si_w),
            .carry_in_i(ci_w),
            .sum_o     (row_sum[j]),
            .carry_o   (row_carry[j])
        );

        assign low_bits[j] = row_sum[j][0];
    end

    cpa_ripple #(.WIDTH(WIDTH)) u_cpa (
        .x_i   ({1'b0, row_sum[WIDTH-1][WIDTH-1:1]}),
        .y_i   (row_carry[WIDTH-1]),
        .cin_i (1'b0),
        .sum_o (high_bits),
        .cout_o(final_cout)
    );

    assign product_o = {high_bits, low_bits};

    always_comb begin
        if (!$isunknown({mcand_i, mplier_i})) begin
            // R7
            no_overflow_chk: assert (final_cout == 1'b0)
                else $error("carry left the top of the product");
            // R1
            product_value_chk: assert (product_o == (PW'(mcand_i) * PW'(mplier_i)))
                else $error("product %0h wrong for %0h x %0h", product_o, mcand_i, mplier_i);
            // R3
            zero_operand_chk: assert (!((mcand_i == '0) || (mplier_i == '0)) || (product_o == '0))
                else $error("zero operand gave nonzero product");
            // R4
            identity_chk: assert (!(mplier_i == WIDTH'(1)) || (product_o == PW'(mcand_i)))
                else $error("multiply by one changed operand");
        end
    end

endmodule

// File: tb/tb_cs_array_mult.sv
`timescale 1ns/1ps
module tb_cs_array_mult;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic [31:0] p16;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cs_array_mult #(.WIDTH(16)) dut (.mcand_i(a16), .mplier_i(b16), .product_o(p16));
    cs_array_mult #(.WIDTH(4))  dut_w4 (.mcand_i(a4), .mplier_i(b4), .product_o(p4));

    task automatic chk16(input logic [15:0] a, input logic [15:0] b, input string req);
        logic [31:0] exp;
        @(negedge clk);
        a16 = a; b16 = b;
        #1;
        exp = {16'h0, a} * {16'h0, b};
        checks++;
        if (p16 !== exp) begin
            errors++;
            $display("FAIL %s: %h x %h got %h expected %h", req, a, b, p16, exp);
        end
    endtask

    task automatic chk4(input logic [3:0] a, input logic [3:0] b, input logic [7:0] exp, input string req);
        @(negedge clk);
        a4 = a; b4 = b;
        #1;
        checks++;
        if (p4 !== exp) begin
            errors++;
            $display("FAIL %s: %h x %h got %h expected %h", req, a, b, p4, exp);
        end
    endtask

    task automatic t_initial_zero;  // R3: both operands zero out of reset
        #1;
        checks++;
        if (p16 !== 32'h0) begin
            errors++;
            $display("FAIL R3: initial got %h expected 0", p16);
        end
    endtask

    task automatic t_exhaustive4;   // R1 at width 4, plus R2
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < 16; k++)
                chk4(4'(i), 4'(k), 8'(i * k), "R1");
        chk4(4'hF, 4'hF, 8'b11100001, "R2");
    endtask

    task automatic t_zero_ops;
        chk16(16'h0000, 16'hBEEF, "R3");
        chk16(16'h1234, 16'h0000, "R3");
        chk16(16'hFFFF, 16'h0000, "R3");
    endtask

    task automatic t_identity;
        chk16(16'h0001, 16'hA5C3, "R4");
        chk16(16'hFFFF, 16'h0001, "R4");
        chk16(16'h0001, 16'h0001, "R4");
    endtask

    task automatic t_all_ones;
        chk16(16'hFFFF, 16'hFFFF, "R8");
        checks++;
        if (p16 !== 32'hFFFE0001) begin
            errors++;
            $display("FAIL R8: got %h expected fffe0001", p16);
        end
    endtask

    task automatic t_random;        // R1, R5, R6, R7 exercised by varied operands
        for (int n = 0; n < 600; n++)
            chk16(16'($urandom), 16'($urandom), "R1");
        chk16(16'h8000, 16'h8000, "R7");
        chk16(16'hAAAA, 16'h5555, "R5");
        chk16(16'hFFFF, 16'h8001, "R6");
    endtask

    task automatic t_same_step;     // R9: no clock edge between input change and result
        @(posedge clk);
        #2;
        a16 = 16'h0300; b16 = 16'h0021;
        #0.1;
        checks++;
        if (p16 !== 32'h00006300) begin
            errors++;
            $display("FAIL R9: got %h expected 00006300", p16);
        end
    endtask

    initial begin
        t_initial_zero();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_exhaustive4();
        t_zero_ops();
        t_identity();
        t_all_ones();
        t_random();
        t_same_step();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule